// File: doc/BRIEF.md
# One-Shot Pulse Timer with Capture Trigger

This block is a 16-bit up-counter that a selected edge on an asynchronous trigger input can restart. In one-shot mode the restart loads the counter with a fixed offset just below wrap-around. At the same moment the output pin takes a programmable start level. The pin takes a programmable end level when the counter has counted through the compare value. The result is a single pulse whose width is set by the compare register and the clock divider. Each trigger sets a capture flag, which can raise an interrupt. A small byte-wide register port gives access to the configuration, the flag, the capture register, the compare register and the live count.

The counter advances on a tick. The tick comes from the system clock divided by 2, 4 or 8, or from rising edges of an external clock that is synchronised into the system domain. A restart places the counter five ticks before it would pass a compare value of zero. Software therefore programs `compare = width_in_ticks - 5`. In one-shot mode the capture register receives a constant instead of the live count. The capture flag clears only through a read of the status register followed by an access to the capture low byte.

Top module: `pulse_timer`

## Requirements
- R1: With one-shot mode on (config bit 0), an active trigger edge loads the counter with 0xFFFC. The counter then advances by one per tick, and the trigger also restarts the clock divider.
- R2: In one-shot mode an active trigger loads the capture register with 0xFFFD (high byte at address 2, low byte at address 3). Without one-shot mode the trigger captures the live count.
- R3: In one-shot mode an active trigger drives the pin to the start level held in config bit 2.
- R4: The pin takes the end level in config bit 3 on the tick that moves the counter off a value equal to the compare register (high byte at address 4, low byte at address 5). The pin keeps that level until the next trigger. A pulse therefore lasts (compare + 5) ticks.
- R5: Every active trigger sets the capture flag (status register at address 1, bit 0). The irq output is high exactly while both the flag and config bit 5 are set.
- R6: The flag clears only on a read or write of address 3 that follows a status read made while the flag was set. An access to address 3 without that earlier status read leaves the flag set. A new trigger cancels a pending status read.
- R7: Config bits 7:6 pick the tick: 00 gives the clock divided by 2, 01 divided by 4, 10 divided by 8, and 11 gives one tick per synchronised rising edge of the external clock.
- R8: With config bit 1 clear, the pin stays low. With one-shot mode off, a trigger does not restart the counter and does not drive the start level.
- R9: Config bit 4 set makes the rising trigger edge active, and clear makes the falling edge active. The other edge does nothing.
- R10: A trigger that arrives during a pulse restarts the pulse, so the pin stays at the start level for (compare + 5) ticks after the second trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extClk | input | 1 | Asynchronous external tick source |
| capIn | input | 1 | Asynchronous trigger input |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (has side effects on the flag) |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data, combinational from addr |
| pulseOut | output | 1 | Pulse output pin |
| irq | output | 1 | Capture interrupt request |

## Verification
The hardest situation to reach is a second trigger that lands mid-pulse. The bench raises, lowers and raises the trigger input eight clocks apart while the first pulse is still running. It then expects one merged pulse that lasts the gap plus a full pulse width. The two-step flag clear is checked in its order-sensitive form. The bench first touches the capture low byte with no status read, which must leave the flag set, and only then reads status before the clearing access. External-clock pulses are checked against a window, because the phase of the first synchronised edge relative to the trigger is free.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int PRE_W  = 3;

  localparam logic [CNT_W-1:0] RESTART_VAL = {CNT_W{1'b1}} - CNT_W'(3);
  localparam logic [CNT_W-1:0] CAPTURE_VAL = {CNT_W{1'b1}} - CNT_W'(2);

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAPH = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAPL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMPH = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMPL = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNTH = 3'd6;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd7;

  typedef struct packed {
    logic tick;
    logic trigRestart;
    logic trigCapture;
    logic cmpHiWr;
    logic cmpLoWr;
  } ptStrobe_t;

  typedef struct packed {
    logic [1:0] clkSel;
    logic       irqEn;
    logic       riseSel;
    logic       levelEnd;
    logic       levelStart;
    logic       outEn;
    logic       oneShot;
  } ptCfg_t;
endpackage

// File: rtl/pt_ctrl.sv
`timescale 1ns/1ps
module pt_ctrl
  import pt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extClk,
  input  logic              capIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  capReg,
  input  logic [CNT_W-1:0]  cmpReg,
  output ptStrobe_t         strb,
  output ptCfg_t            cfg,
  output logic              capFlag,
  output logic              clrArmed,
  output logic [BYTE_W-1:0] rdData,
  output logic              irq
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0]  capSh, extSh;
  logic             trig, extEdge, capLAccess, statusRead;
  logic [PRE_W-1:0] preCnt, preLimit;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      capSh <= '0;
      extSh <= '0;
    end else begin
      capSh <= {capSh[SH_W-2:0], capIn};
      extSh <= {extSh[SH_W-2:0], extClk};
    end

  assign trig    = cfg.riseSel ? (capSh[SH_W-2] & ~capSh[SH_W-1])
                               : (~capSh[SH_W-2] & capSh[SH_W-1]);
  assign extEdge = extSh[SH_W-2] & ~extSh[SH_W-1];

  always_comb
    case (cfg.clkSel)
      2'b00:   preLimit = PRE_W'(1);
      2'b01:   preLimit = PRE_W'(3);
      default: preLimit = PRE_W'(7);
    endcase

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                    preCnt <= '0;
    else if (strb.trigRestart)    preCnt <= '0;
    else if (preCnt >= preLimit)  preCnt <= '0;
    else                          preCnt <= preCnt + PRE_W'(1);

  assign strb.tick        = (cfg.clkSel == 2'b11) ? extEdge : (preCnt == preLimit);
  assign strb.trigRestart = trig & cfg.oneShot;
  assign strb.trigCapture = trig;
  assign strb.cmpHiWr     = wrEn && (addr == A_CMPH);
  assign strb.cmpLoWr     = wrEn && (addr == A_CMPL);

  assign capLAccess = (wrEn || rdEn) && (addr == A_CAPL);
  assign statusRead = rdEn && (addr == A_STAT);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                          cfg <= '0;
    else if (wrEn && (addr == A_CFG))   cfg <= ptCfg_t'(wrData);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                          capFlag <= 1'b0;
    else if (trig)                      capFlag <= 1'b1;
    else if (capLAccess && clrArmed)    capFlag <= 1'b0;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                          clrArmed <= 1'b0;
    else if (trig || capLAccess)        clrArmed <= 1'b0;
    else if (statusRead && capFlag)     clrArmed <= 1'b1;

  always_comb
    case (addr)
      A_CFG:   rdData = BYTE_W'(cfg);
      A_STAT:  rdData = {{(BYTE_W-1){1'b0}}, capFlag};
      A_CAPH:  rdData = capReg[CNT_W-1:BYTE_W];
      A_CAPL:  rdData = capReg[BYTE_W-1:0];
      A_CMPH:  rdData = cmpReg[CNT_W-1:BYTE_W];
      A_CMPL:  rdData = cmpReg[BYTE_W-1:0];
      A_CNTH:  rdData = count[CNT_W-1:BYTE_W];
      default: rdData = count[BYTE_W-1:0];
    endcase

  assign irq = capFlag & cfg.irqEn;
endmodule

// File: rtl/pt_datapath.sv
`timescale 1ns/1ps
module pt_datapath
  import pt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ptStrobe_t         strb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              levelStart,
  input  logic              levelEnd,
  input  logic              outEn,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  capReg,
  output logic [CNT_W-1:0]  cmpReg,
  output logic              pulseOut
);
  logic level, passMatch;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                  count <= '0;
    else if (strb.trigRestart)  count <= RESTART_VAL;
    else if (strb.tick)         count <= count + CNT_W'(1);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                  capReg <= '0;
    else if (strb.trigRestart)  capReg <= CAPTURE_VAL;
    else if (strb.trigCapture)  capReg <= count;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) cmpReg <= '0;
    else begin
      if (strb.cmpHiWr) cmpReg[CNT_W-1:BYTE_W] <= wrData;
      if (strb.cmpLoWr) cmpReg[BYTE_W-1:0]     <= wrData;
    end

  assign passMatch = strb.tick && (count == cmpReg);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                  level <= 1'b0;
    else if (strb.trigRestart)  level <= levelStart;
    else if (passMatch)         level <= levelEnd;

  assign pulseOut = outEn & level;
endmodule

// File: rtl/pulse_timer.sv
`timescale 1ns/1ps
module pulse_timer
  import pt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              extClk,
  input  logic              capIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              pulseOut,
  output logic              irq
);
  ptStrobe_t        strb;
  ptCfg_t           cfg;
  logic             capFlag, clrArmed;
  logic [CNT_W-1:0] count, capReg, cmpReg;

  pt_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .extClk(extClk), .capIn(capIn),
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .count(count), .capReg(capReg), .cmpReg(cmpReg),
    .strb(strb), .cfg(cfg), .capFlag(capFlag), .clrArmed(clrArmed),
    .rdData(rdData), .irq(irq)
  );

  pt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .levelStart(cfg.levelStart), .levelEnd(cfg.levelEnd), .outEn(cfg.outEn),
    .count(count), .capReg(capReg), .cmpReg(cmpReg), .pulseOut(pulseOut)
  );
endmodule

// File: rtl/pt_checker.sv
`timescale 1ns/1ps
module pt_checker
  import pt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input ptStrobe_t        strb,
  input ptCfg_t           cfg,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] capReg,
  input logic             capFlag,
  input logic             clrArmed,
  input logic             pulseOut
);
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.trigRestart |=> count == RESTART_VAL); // R1
  AST_CAPTURE_CONST: assert property (@(posedge clk) disable iff (!rstN)
    strb.trigRestart |=> capReg == CAPTURE_VAL); // R2
  AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.trigRestart && cfg.outEn) |=> (pulseOut == $past(cfg.levelStart)) || !cfg.outEn); // R3
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.trigCapture |=> capFlag); // R5
  AST_FLAG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !clrArmed) |=> capFlag); // R6
  AST_PIN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.outEn |-> !pulseOut); // R8
endmodule

bind pulse_timer pt_checker u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg), .count(count),
  .capReg(capReg), .capFlag(capFlag), .clrArmed(clrArmed), .pulseOut(pulseOut)
);

// File: tb/pulse_timer_test.sv
`timescale 1ns/1ps
module pulse_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extClk = 1'b0;
  logic       capIn = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       pulseOut, irq;

  int vectors = 0;
  int fails = 0;
  bit extRun = 1'b0;

  typedef struct { int lo; int hi; string req; } pulseExp_t;
  pulseExp_t expQ[$];

  pulse_timer uut (
    .clk(clk), .rstN(rstN), .extClk(extClk), .capIn(capIn), .addr(addr),
    .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .rdData(rdData),
    .pulseOut(pulseOut), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // external tick source: period of six system clocks when running
  initial forever begin
    @(negedge clk);
    if (extRun) begin
      repeat (2) @(negedge clk);
      extClk = ~extClk;
    end
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expectPulse(int lo, int hi, string req);
    pulseExp_t e;
    e.lo = lo; e.hi = hi; e.req = req;
    expQ.push_back(e);
  endtask

  // monitor: measures each high phase of the pin and compares with the queue
  int  hiCnt = 0;
  bit  prevPin = 1'b0;
  always @(negedge clk) begin
    if (pulseOut) hiCnt++;
    else if (prevPin) begin
      vectors++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL unexpected pulse: actual %0d expected none", hiCnt);
      end else begin
        pulseExp_t e;
        e = expQ.pop_front();
        if (hiCnt < e.lo || hiCnt > e.hi) begin
          fails++;
          $display("FAIL %s pulse width: actual %0d expected %0d..%0d", e.req, hiCnt, e.lo, e.hi);
        end
      end
      hiCnt = 0;
    end
    prevPin = pulseOut;
  end

  task automatic regWr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setCmp(input logic [15:0] v);
    regWr(3'd4, v[15:8]);
    regWr(3'd5, v[7:0]);
  endtask

  task automatic drvCap(input logic v);
    @(negedge clk);
    capIn = v;
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearFlag();
    logic [7:0] d;
    regRd(3'd1, d);
    regRd(3'd3, d);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int hits;
    waitClk(4);
    rstN = 1'b1;
    waitClk(2);

    // reset state
    check("R5 reset pin", int'(pulseOut), 0);
    check("R5 reset irq", int'(irq), 0);
    regRd(3'd1, d); check("R5 reset flag", int'(d), 0);
    regRd(3'd2, d); check("R2 reset capture high", int'(d), 0);

    // R1 R3 R4 R7: divide by 2, compare 3 -> 8 ticks of 2 clocks
    setCmp(16'd3);
    regWr(3'd0, 8'h37);
    expectPulse(16, 16, "R1 R4 R7 div2");
    drvCap(1'b1);
    waitClk(40);
    check("R4 end level held", int'(pulseOut), 0);

    // R2 and R6 ordering, R5 irq
    regRd(3'd3, d); check("R2 capture low", int'(d), 'hFD);
    regRd(3'd2, d); check("R2 capture high", int'(d), 'hFF);
    regRd(3'd1, d); check("R6 flag kept after unarmed access", int'(d), 1);
    check("R5 irq with enable", int'(irq), 1);
    regRd(3'd3, d);
    regRd(3'd1, d); check("R6 flag cleared after status then capture-low", int'(d), 0);
    check("R5 irq low after clear", int'(irq), 0);

    // R9: falling edge ignored while rising selected
    drvCap(1'b0);
    waitClk(20);
    regRd(3'd1, d); check("R9 inactive edge ignored", int'(d), 0);

    // R7: divide by 4, compare 0 -> 5 ticks of 4 clocks
    setCmp(16'd0);
    regWr(3'd0, 8'h77);
    expectPulse(20, 20, "R7 div4");
    drvCap(1'b1);
    waitClk(60);
    drvCap(1'b0);

    // R7: divide by 8, compare 1 -> 6 ticks of 8 clocks
    setCmp(16'd1);
    regWr(3'd0, 8'hB7);
    expectPulse(48, 48, "R7 div8");
    drvCap(1'b1);
    waitClk(100);
    drvCap(1'b0);
    waitClk(10);

    // R10: retrigger 8 clocks after the first trigger, divide by 2, compare 3
    setCmp(16'd3);
    regWr(3'd0, 8'h37);
    expectPulse(24, 24, "R10 retrigger");
    drvCap(1'b1);
    waitClk(3);
    drvCap(1'b0);
    waitClk(3);
    drvCap(1'b1);
    waitClk(60);
    drvCap(1'b0);
    waitClk(10);

    // R9: falling edge active
    clearFlag();
    regWr(3'd0, 8'h27);
    drvCap(1'b1);
    waitClk(10);
    regRd(3'd1, d); check("R9 rising ignored with falling select", int'(d), 0);
    check("R9 pin idle on ignored edge", int'(pulseOut), 0);
    expectPulse(16, 16, "R9 falling trigger");
    drvCap(1'b0);
    waitClk(40);
    regRd(3'd1, d); check("R9 falling edge sets flag", int'(d), 1);

    // R7: external clock, 6-clock period, compare 2 -> 7 ticks, phase free
    clearFlag();
    setCmp(16'd2);
    regWr(3'd0, 8'hF7);
    extRun = 1'b1;
    waitClk(12);
    expectPulse(37, 42, "R7 external clock");
    drvCap(1'b1);
    waitClk(80);
    drvCap(1'b0);
    extRun = 1'b0;
    waitClk(10);

    // R8: one-shot off, pin must not take the start level
    clearFlag();
    setCmp(16'h8000);
    regWr(3'd0, 8'h36);
    hits = 0;
    drvCap(1'b1);
    repeat (30) begin @(negedge clk); #1 if (pulseOut) hits++; end
    check("R8 no start level without one-shot", hits, 0);
    regRd(3'd1, d); check("R5 flag set without one-shot", int'(d), 1);
    drvCap(1'b0);

    // R8: output disabled, pin stays low through a one-shot pulse
    setCmp(16'd3);
    regWr(3'd0, 8'h35);
    hits = 0;
    drvCap(1'b1);
    repeat (30) begin @(negedge clk); #1 if (pulseOut) hits++; end
    check("R8 pin low when output disabled", hits, 0);
    drvCap(1'b0);
    waitClk(10);

    check("R4 all expected pulses seen", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule